// File: doc/BRIEF.md
# APB Slave-Timeout Error Handler

This block sits beside an APB bus that has a single bridge master. It watches every transfer on that bus. When the addressed slave holds PREADY low for longer than a programmable number of clock cycles, the block takes over and completes the transfer itself with an error. It then records the address of the transfer and raises a level interrupt. The same mechanism catches accesses to address windows where no device is mapped, because nothing ever answers them.

The bridge's response inputs are routed through the block. While no timeout is in progress, the slave's ready, error and read data pass straight through. When a transfer times out, the block drives ready high, error high and read data zero for that one cycle. A small register window on a second APB port lets software do the following:

- read the status bits;
- clear or inject the pending flag;
- enable the interrupt;
- read the captured address;
- set the cycle limit, which has a lower bound.

Top module: `apb_hang_guard`

## Requirements
- R1: After reset the status register (offset 0x00) reads 0, the fault address register (offset 0x04) reads 0, the limit register (offset 0x08) reads 0x3FF, and `irq` is low.
- R2: `irq` is an active-high level. It is high exactly when status bit 0 (pending) and status bit 1 (enable) are both 1. Status bits 31:2 read as 0.
- R3: A write to the limit register stores the written value, except that any value below 0x3FF is stored as 0x3FF. Values up to 0xFFFFFFFF are stored unchanged.
- R4: With limit T, a slave that has not raised ready in the first T access-phase cycles of a transfer is cut off. In access cycle T+1 the master side sees ready=1, error=1 and read data 0, and the slave's own response in that cycle is ignored.
- R5: A slave that raises ready within its first T access cycles completes normally. Its error flag and read data pass through unchanged. The wait count restarts at zero for every new access phase.
- R6: A timeout that occurs while pending is 0 stores the full transfer address in the fault address register and sets pending.
- R7: A timeout that occurs while pending is already 1 leaves the fault address register unchanged.
- R8: A write to the status register loads bit 0 into pending (0 clears it, 1 injects an interrupt with no fault) and bit 1 into enable.
- R9: The fault address register ignores writes. An unmapped offset (0x0C) reads as 0, and writes to it change nothing.
- R10: When a timeout and a software write to the status register land in the same cycle, pending ends up 1. The enable bit still takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Select from the bridge (any slave) |
| bus_enable | input | 1 | Access-phase strobe from the bridge |
| bus_addr | input | ADDR_W | Transfer address from the bridge |
| slv_ready | input | 1 | Ready returned by the selected slave |
| slv_err | input | 1 | Error returned by the selected slave |
| slv_rdata | input | DATA_W | Read data returned by the selected slave |
| mst_ready | output | 1 | Ready seen by the bridge |
| mst_err | output | 1 | Error seen by the bridge |
| mst_rdata | output | DATA_W | Read data seen by the bridge |
| csr_sel | input | 1 | Register port select |
| csr_enable | input | 1 | Register port access strobe |
| csr_write | input | 1 | Register port direction, 1 = write |
| csr_addr | input | CSR_AW | Register port byte offset |
| csr_wdata | input | DATA_W | Register port write data |
| csr_rdata | output | DATA_W | Register port read data |
| csr_ready | output | 1 | Register port ready, always high |
| irq | output | 1 | Fault interrupt, active-high level |

## Verification
The hardest case to reach from the ports is a timeout and a software status write completing on the same clock edge (R10). The bench reaches it by running a stalled monitored transfer and a register-port write in parallel threads. The write's setup phase is delayed by exactly T-1 clock cycles, so its access phase meets the expiry cycle. The latency sweep places the slave's ready one cycle before, on, and after the limit for two limit values. This exposes any off-by-one in the wait count.

// File: rtl/apb_hang_guard_pkg.sv
`timescale 1ns/1ps
// Shared constants for the APB hang guard: register offsets and status bit
// positions. Software decodes these, so they are fixed.
package apb_hang_guard_pkg;
    localparam int unsigned OFS_STAT  = 32'h0;
    localparam int unsigned OFS_FADDR = 32'h4;
    localparam int unsigned OFS_LIMIT = 32'h8;
    localparam int unsigned PEND_BIT  = 0;
    localparam int unsigned EN_BIT    = 1;
    localparam int unsigned LIMIT_FLOOR_DEFAULT = 32'h3FF;
endpackage

// File: rtl/apb_hang_guard_timer.sv
`timescale 1ns/1ps
// Wait counter for one monitored transfer.
// Counts access-phase cycles in which the slave has not answered.
// `expire` is high in the cycle after `limit` such cycles have passed.
// Assumes legal APB: an access phase is always preceded by a setup phase,
// so the count is zero at the start of every access phase.
module apb_hang_guard_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_access,
    input  logic             slv_ready,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] waited;

    // Expiry compares with >= so that a limit lowered mid-transfer still fires.
    assign expire = in_access && (waited >= limit);

    // Advance while stalled; restart when idle or when the transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waited <= '0;
        end else if (!in_access || slv_ready || expire) begin
            waited <= '0;
        end else begin
            waited <= waited + 1'b1;
        end
    end
endmodule

// File: rtl/apb_hang_guard_fault.sv
`timescale 1ns/1ps
// Holds the pending flag, the interrupt enable and the captured fault
// address, and forms the interrupt.
// A timeout beats a software write to pending in the same cycle.
// The address is captured only while pending is clear.
module apb_hang_guard_fault #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic              sw_we,
    input  logic              sw_pend,
    input  logic              sw_en,
    output logic              pend,
    output logic              irq_en,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              irq
);
    // Pending flag: set by a fault, otherwise loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (expire) begin
            pend <= 1'b1;
        end else if (sw_we) begin
            pend <= sw_pend;
        end
    end

    // Interrupt enable: software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (sw_we) begin
            irq_en <= sw_en;
        end
    end

    // Fault address: first fault since pending was last cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr <= '0;
        end else if (expire && !pend) begin
            fault_addr <= xfer_addr;
        end
    end

    assign irq = pend & irq_en;
endmodule

// File: rtl/apb_hang_guard_csr.sv
`timescale 1ns/1ps
// Register window on the control APB port: status, fault address, limit.
// The port always responds with zero wait states.
// Assumes ADDR_W and TMO_W are no wider than DATA_W.
module apb_hang_guard_csr #(
    parameter int          CSR_AW    = 4,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 32,
    parameter int          TMO_W     = 32,
    parameter int unsigned TMO_FLOOR = 32'h3FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              enable,
    input  logic              write,
    input  logic [CSR_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              stat_we,
    output logic              sw_pend,
    output logic              sw_en,
    output logic [TMO_W-1:0]  limit,
    input  logic              pend,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] fault_addr
);
    import apb_hang_guard_pkg::*;

    localparam logic [CSR_AW-1:0] A_STAT  = CSR_AW'(OFS_STAT);
    localparam logic [CSR_AW-1:0] A_FADDR = CSR_AW'(OFS_FADDR);
    localparam logic [CSR_AW-1:0] A_LIMIT = CSR_AW'(OFS_LIMIT);
    localparam logic [TMO_W-1:0]  FLOOR   = TMO_W'(TMO_FLOOR);

    logic              wr_cycle;
    logic [TMO_W-1:0]  wr_limit;

    assign wr_cycle = sel && enable && write;
    assign stat_we  = wr_cycle && (addr == A_STAT);
    assign sw_pend  = wdata[PEND_BIT];
    assign sw_en    = wdata[EN_BIT];
    assign wr_limit = wdata[TMO_W-1:0];

    // Limit register: clamp writes below the floor up to the floor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit <= FLOOR;
        end else if (wr_cycle && (addr == A_LIMIT)) begin
            limit <= (wr_limit < FLOOR) ? FLOOR : wr_limit;
        end
    end

    // Read multiplexer: unmapped offsets and writes return zero.
    always_comb begin
        rdata = '0;
        if (sel && !write) begin
            case (addr)
                A_STAT:  rdata = DATA_W'({irq_en, pend});
                A_FADDR: rdata = DATA_W'(fault_addr);
                A_LIMIT: rdata = DATA_W'(limit);
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/apb_hang_guard.sv
`timescale 1ns/1ps
// APB slave-timeout error handler (top).
// Observes the bridge-to-slave transfer and passes the slave response
// through. If the slave stalls past the programmed limit, it completes the
// transfer itself with an error and records the fault.
// Assumes a single bridge master and a muxed slave response.
module apb_hang_guard #(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          CSR_AW    = 4,
    parameter int          TMO_W     = 32,
    parameter int unsigned TMO_FLOOR = apb_hang_guard_pkg::LIMIT_FLOOR_DEFAULT
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              bus_sel,
    input  logic              bus_enable,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              slv_ready,
    input  logic              slv_err,
    input  logic [DATA_W-1:0] slv_rdata,
    output logic              mst_ready,
    output logic              mst_err,
    output logic [DATA_W-1:0] mst_rdata,
    input  logic              csr_sel,
    input  logic              csr_enable,
    input  logic              csr_write,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              csr_ready,
    output logic              irq
);
    logic              in_access;
    logic              expire;
    logic              stat_we;
    logic              sw_pend;
    logic              sw_en;
    logic              pend;
    logic              irq_en;
    logic [TMO_W-1:0]  limit;
    logic [ADDR_W-1:0] fault_addr;

    assign in_access = bus_sel && bus_enable;
    assign csr_ready = 1'b1;

    apb_hang_guard_timer #(.CNT_W(TMO_W)) timer_i (
        .clk       (pclk),
        .rst_n     (presetn),
        .in_access (in_access),
        .slv_ready (slv_ready),
        .limit     (limit),
        .expire    (expire)
    );

    apb_hang_guard_fault #(.ADDR_W(ADDR_W)) fault_i (
        .clk        (pclk),
        .rst_n      (presetn),
        .expire     (expire),
        .xfer_addr  (bus_addr),
        .sw_we      (stat_we),
        .sw_pend    (sw_pend),
        .sw_en      (sw_en),
        .pend       (pend),
        .irq_en     (irq_en),
        .fault_addr (fault_addr),
        .irq        (irq)
    );

    apb_hang_guard_csr #(
        .CSR_AW    (CSR_AW),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .TMO_W     (TMO_W),
        .TMO_FLOOR (TMO_FLOOR)
    ) csr_i (
        .clk        (pclk),
        .rst_n      (presetn),
        .sel        (csr_sel),
        .enable     (csr_enable),
        .write      (csr_write),
        .addr       (csr_addr),
        .wdata      (csr_wdata),
        .rdata      (csr_rdata),
        .stat_we    (stat_we),
        .sw_pend    (sw_pend),
        .sw_en      (sw_en),
        .limit      (limit),
        .pend       (pend),
        .irq_en     (irq_en),
        .fault_addr (fault_addr)
    );

    // Response steering: the terminator replaces the slave in the expiry cycle.
    always_comb begin
        if (expire) begin
            mst_ready = 1'b1;
            mst_err   = 1'b1;
            mst_rdata = '0;
        end else begin
            mst_ready = slv_ready;
            mst_err   = slv_err;
            mst_rdata = slv_rdata;
        end
    end
endmodule

// File: rtl/apb_hang_guard_chk.sv
`timescale 1ns/1ps
// Property checker for apb_hang_guard, attached by bind.
module apb_hang_guard_chk #(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          TMO_W     = 32,
    parameter int unsigned TMO_FLOOR = 32'h3FF
) (
    input logic              pclk,
    input logic              presetn,
    input logic              bus_sel,
    input logic              bus_enable,
    input logic              slv_ready,
    input logic              slv_err,
    input logic [DATA_W-1:0] slv_rdata,
    input logic              mst_ready,
    input logic              mst_err,
    input logic [DATA_W-1:0] mst_rdata,
    input logic              irq,
    input logic              expire,
    input logic              pend,
    input logic              irq_en,
    input logic [TMO_W-1:0]  limit,
    input logic [ADDR_W-1:0] fault_addr
);
    assert_limit_floor_R3: assert property (@(posedge pclk) disable iff (!presetn)
        limit >= TMO_W'(TMO_FLOOR));

    assert_irq_gated_R2: assert property (@(posedge pclk) disable iff (!presetn)
        !irq_en |-> !irq);

    assert_timeout_resp_R4: assert property (@(posedge pclk) disable iff (!presetn)
        (bus_sel && bus_enable && mst_err && !slv_err) |-> (mst_ready && mst_rdata == '0));

    assert_expire_once_R4: assert property (@(posedge pclk) disable iff (!presetn)
        expire |=> !expire);

    assert_normal_pass_R5: assert property (@(posedge pclk) disable iff (!presetn)
        (bus_sel && bus_enable && slv_ready && !expire) |-> (mst_ready && mst_rdata == slv_rdata));

    assert_fault_pends_R6: assert property (@(posedge pclk) disable iff (!presetn)
        expire |=> pend);

    assert_addr_held_R7: assert property (@(posedge pclk) disable iff (!presetn)
        pend |=> $stable(fault_addr));
endmodule

bind apb_hang_guard apb_hang_guard_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .TMO_W     (TMO_W),
    .TMO_FLOOR (TMO_FLOOR)
) chk_i (
    .pclk       (pclk),
    .presetn    (presetn),
    .bus_sel    (bus_sel),
    .bus_enable (bus_enable),
    .slv_ready  (slv_ready),
    .slv_err    (slv_err),
    .slv_rdata  (slv_rdata),
    .mst_ready  (mst_ready),
    .mst_err    (mst_err),
    .mst_rdata  (mst_rdata),
    .irq        (irq),
    .expire     (expire),
    .pend       (pend),
    .irq_en     (irq_en),
    .limit      (limit),
    .fault_addr (fault_addr)
);

// File: tb/apb_hang_guard_tb.sv
`timescale 1ns/1ps
// Self-checking bench: limit clamp sweep, status sweep, slave latency sweep
// around two limit values, fault address retention and the same-cycle race.
module apb_hang_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_sel = 1'b0, b_en = 1'b0;
    logic [31:0] b_addr = '0;
    logic        s_ready = 1'b0, s_err = 1'b0;
    logic [31:0] s_data = '0;
    logic        m_ready, m_err;
    logic [31:0] m_data;
    logic        c_sel = 1'b0, c_en = 1'b0, c_wr = 1'b0;
    logic [3:0]  c_addr = '0;
    logic [31:0] c_wdata = '0;
    logic [31:0] c_rdata;
    logic        c_ready;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    apb_hang_guard dut_i (
        .pclk(clk), .presetn(rst_n),
        .bus_sel(b_sel), .bus_enable(b_en), .bus_addr(b_addr),
        .slv_ready(s_ready), .slv_err(s_err), .slv_rdata(s_data),
        .mst_ready(m_ready), .mst_err(m_err), .mst_rdata(m_data),
        .csr_sel(c_sel), .csr_enable(c_en), .csr_write(c_wr),
        .csr_addr(c_addr), .csr_wdata(c_wdata), .csr_rdata(c_rdata),
        .csr_ready(c_ready), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] want);
        n_chk++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, want);
        end
    endtask

    task automatic csr_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); c_sel = 1'b1; c_en = 1'b0; c_wr = 1'b1; c_addr = a; c_wdata = d;
        @(negedge clk); c_en = 1'b1;
        @(negedge clk); c_sel = 1'b0; c_en = 1'b0; c_wr = 1'b0;
    endtask

    task automatic csr_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); c_sel = 1'b1; c_en = 1'b0; c_wr = 1'b0; c_addr = a;
        @(negedge clk); c_en = 1'b1; #1; d = c_rdata;
        @(negedge clk); c_sel = 1'b0; c_en = 1'b0;
    endtask

    // One monitored transfer; the slave raises ready after `lat` wait cycles.
    task automatic mon_xfer(input logic [31:0] a, input int lat, input logic serr,
                            input logic [31:0] sdata, output int done_at,
                            output logic got_err, output logic [31:0] got_data);
        done_at = -1; got_err = 1'b0; got_data = '0;
        @(negedge clk); b_sel = 1'b1; b_en = 1'b0; b_addr = a; s_ready = 1'b0;
        @(negedge clk); b_en = 1'b1;
        for (int k = 0; k < 100000; k++) begin
            s_ready = (k == lat); s_err = serr; s_data = sdata;
            #1;
            if (m_ready) begin
                done_at = k; got_err = m_err; got_data = m_data;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk); b_sel = 1'b0; b_en = 1'b0; s_ready = 1'b0; s_err = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] last_fault;
        int          done_at;
        logic        gerr;
        logic [31:0] gdata;
        int          lims [2];
        int          lats [6];
        logic [31:0] addr_a, addr_b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        csr_rd(4'h0, rd); chk("R1 status", rd, 32'h0);
        csr_rd(4'h4, rd); chk("R1 fault addr", rd, 32'h0);
        csr_rd(4'h8, rd); chk("R1 limit", rd, 32'h3FF);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        last_fault = '0;

        // R3 limit clamp sweep
        begin
            logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h3FE, 32'h3FF, 32'h400,
                                      32'h12345678, 32'hFFFFFFFF, 32'h200};
            foreach (vals[i]) begin
                csr_wr(4'h8, vals[i]);
                csr_rd(4'h8, rd);
                chk("R3 limit clamp", rd, (vals[i] < 32'h3FF) ? 32'h3FF : vals[i]);
            end
        end

        // R8/R2 status sweep: bit0 pending, bit1 enable, upper bits read 0
        for (int v = 0; v < 4; v++) begin
            csr_wr(4'h0, 32'hFFFF_FFFC | 32'(v));
            csr_rd(4'h0, rd);
            chk("R8 status load", rd, 32'(v));
            chk("R2 irq level", {31'b0, irq}, (v == 3) ? 32'h1 : 32'h0);
        end

        // R4/R5/R6 latency sweep around two limits
        lims = '{32'h3FF, 32'h400};
        foreach (lims[li]) begin
            int t;
            t = lims[li];
            csr_wr(4'h8, 32'(t));
            lats = '{0, 1, 3, t - 1, t, t + 7};
            foreach (lats[j]) begin
                int          lat;
                logic        timed;
                logic [31:0] a;
                logic [31:0] sd;
                lat   = lats[j];
                timed = (lat >= t);
                a     = 32'hD000_0000 + 32'(lat * 4) + 32'(t);
                sd    = 32'hA500_0000 ^ 32'(lat);
                csr_wr(4'h0, 32'h2);
                mon_xfer(a, lat, (lat == 1), sd, done_at, gerr, gdata);
                if (timed) begin
                    chk("R4 cutoff cycle", 32'(done_at), 32'(t));
                    chk("R4 error flag", {31'b0, gerr}, 32'h1);
                    chk("R4 zero data", gdata, 32'h0);
                    last_fault = a;
                    csr_rd(4'h4, rd); chk("R6 captured addr", rd, a);
                    csr_rd(4'h0, rd); chk("R6 pending set", rd, 32'h3);
                    chk("R2 irq on fault", {31'b0, irq}, 32'h1);
                end else begin
                    chk("R5 normal cycle", 32'(done_at), 32'(lat));
                    chk("R5 slave err pass", {31'b0, gerr}, (lat == 1) ? 32'h1 : 32'h0);
                    chk("R5 slave data pass", gdata, sd);
                    csr_rd(4'h0, rd); chk("R5 no pending", rd, 32'h2);
                    csr_rd(4'h4, rd); chk("R5 addr untouched", rd, last_fault);
                end
            end
        end

        // R9 read-only address and unmapped offset
        csr_wr(4'h4, 32'hFFFF_FFFF);
        csr_rd(4'h4, rd); chk("R9 addr ignores write", rd, last_fault);
        csr_wr(4'hC, 32'h0000_5555);
        csr_rd(4'hC, rd); chk("R9 unmapped reads 0", rd, 32'h0);
        csr_rd(4'h8, rd); chk("R9 limit unaffected", rd, 32'h400);

        // R10 timeout and status write in the same cycle
        csr_wr(4'h8, 32'h3FF);
        csr_wr(4'h0, 32'h0);
        addr_a = 32'h1D00_0040;
        fork
            mon_xfer(addr_a, 100000, 1'b0, 32'h0, done_at, gerr, gdata);
            begin
                @(negedge clk);
                repeat (32'h3FF - 1) @(negedge clk);
                csr_wr(4'h0, 32'h2);
            end
        join
        chk("R10 cutoff cycle", 32'(done_at), 32'h3FF);
        csr_rd(4'h0, rd); chk("R10 fault wins over clear", rd, 32'h3);
        csr_rd(4'h4, rd); chk("R10 addr captured", rd, addr_a);
        chk("R10 irq", {31'b0, irq}, 32'h1);

        // R7 second fault while pending keeps first address
        addr_b = 32'h1D00_0888;
        mon_xfer(addr_b, 100000, 1'b0, 32'h0, done_at, gerr, gdata);
        chk("R7 second cutoff err", {31'b0, gerr}, 32'h1);
        csr_rd(4'h4, rd); chk("R7 first addr kept", rd, addr_a);

        // R8 clear by writing 0
        csr_wr(4'h0, 32'h0);
        csr_rd(4'h0, rd); chk("R8 clear", rd, 32'h0);
        chk("R8 irq low", {31'b0, irq}, 32'h0);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule